// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block creates the 16x oversampling enable pulse that paces a UART transmitter and receiver. It does not count down an integer divisor. It adds a 16-bit rate increment to a 16-bit phase accumulator on every system clock. Each carry out of the accumulator becomes a single-cycle tick. The tick rate is therefore f_clk × increment / 2^16, and this equals 16 × baud when software programs increment = baud × 2^20 / f_clk. With a 100 MHz reference clock the highest usable baud rate is f_clk / 16.

Software loads the increment as two byte-wide writes, one for the upper byte and one for the lower byte, and switches the generator on and off through a control write. Increment writes are only honoured while the generator is off and the transmitter reports that it is idle. Turning the generator off clears the phase, so every enable starts from phase zero. An `enabled` output reports the current state of the enable bit.

Top module: `baud_nco`

## Requirements
- R1: After reset, `tick` is 0, `enabled` is 0, the increment is 0 and the phase is 0.
- R2: A write to address 0x0C loads `wr_data[7:0]` into increment bits 15:8. Bits 31:8 of the write data have no effect.
- R3: A write to address 0x10 loads `wr_data[7:0]` into increment bits 7:0. Bits 31:8 of the write data have no effect.
- R4: A write to address 0x14 sets the enable bit from `wr_data[0]`. `enabled` shows the new value from the cycle after the write.
- R5: While enabled, the number of `tick` pulses over N cycles equals N × increment / 65536, within ±1.
- R6: An increment of zero produces no ticks.
- R7: While the generator is disabled, the phase is held at zero and `tick` stays low.
- R8: Increment writes are ignored while the generator is enabled or while `tx_busy` is high.
- R9: For any increment of 0x8000 or less, a tick is never followed by another tick on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Byte offset of the register write |
| wr_data | input | 32 | Write data; only the low byte or bit 0 is used |
| tx_busy | input | 1 | High while the transmitter is shifting out a character |
| tick | output | 1 | One-cycle 16x oversampling enable |
| enabled | output | 1 | Current state of the enable bit |

## Verification
The bench counts ticks over fixed windows for directed increments (0x0001, 0x0100, 0x4000, 0x8000, 0xFFFF and zero) and for seeded random increments. A design with a wrong carry width or a swapped byte would miss the expected count by far more than one tick. It writes junk into the upper data bits, so a decoder that takes too many bits produces the wrong rate. It attempts increment writes while enabled and while `tx_busy` is high; a design that accepts them would switch to the new rate. It also checks that ticks stop when the generator is disabled, which would fail if the phase were not cleared, and that low increments never produce back-to-back ticks.

// File: rtl/baud_nco_pkg.sv
package baud_nco_pkg;
    localparam int ACC_W  = 16;
    localparam int NBYTES = ACC_W / 8;

    typedef struct packed {
        logic [ACC_W-1:0] inc;
        logic             en;
    } cfg_t;

    typedef struct packed {
        logic [ACC_W-1:0] phase;
        logic             tick;
    } acc_t;
endpackage

// File: rtl/baud_inc_regs.sv
module baud_inc_regs
    import baud_nco_pkg::*;
#(
    parameter int               ADDR_W  = 6,
    parameter int               DATA_W  = 32,
    parameter logic [ADDR_W-1:0] OFS_LO  = 6'h10,
    parameter logic [ADDR_W-1:0] OFS_CTL = 6'h14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tx_busy,
    output logic [ACC_W-1:0]  inc,
    output logic              en
);
    localparam int STRIDE = 4;

    cfg_t cfg_d, cfg_q;
    logic [NBYTES-1:0] byte_hit;
    logic              ctl_hit;
    logic              load_ok;

    // Byte k sits STRIDE bytes below byte k-1; the lowest byte at OFS_LO.
    for (genvar k = 0; k < NBYTES; k++) begin : g_byte
        localparam logic [ADDR_W-1:0] OFS_K = ADDR_W'(int'(OFS_LO) - STRIDE * k);
        assign byte_hit[k] = wr_en && (wr_addr == OFS_K);
    end

    assign ctl_hit = wr_en && (wr_addr == OFS_CTL);
    assign load_ok = !cfg_q.en && !tx_busy;

    always_comb begin
        cfg_d = cfg_q;
        for (int k = 0; k < NBYTES; k++) begin
            if (byte_hit[k] && load_ok) begin
                cfg_d.inc[k*8 +: 8] = wr_data[7:0];
            end
        end
        if (ctl_hit) begin
            cfg_d.en = wr_data[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign inc = cfg_q.inc;
    assign en  = cfg_q.en;

    // R8: rate may only move while off and transmitter idle
    a_r8_hold_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.en || tx_busy) |=> $stable(cfg_q.inc));

    // R4: control write lands on the next cycle
    a_r4_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_hit |=> (cfg_q.en == $past(wr_data[0])));
endmodule

// File: rtl/baud_phase_acc.sv
module baud_phase_acc
    import baud_nco_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [ACC_W-1:0] inc,
    output logic             tick
);
    acc_t acc_d, acc_q;
    logic [ACC_W:0] sum;

    always_comb begin
        sum   = {1'b0, acc_q.phase} + {1'b0, inc};
        acc_d = acc_q;
        if (en) begin
            acc_d.phase = sum[ACC_W-1:0];
            acc_d.tick  = sum[ACC_W];
        end else begin
            acc_d.phase = '0;
            acc_d.tick  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign tick = acc_q.tick;

    // R7: disabled generator keeps zero phase and no tick
    a_r7_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (acc_q.phase == '0 && !tick));

    // R6: zero increment never carries
    a_r6_zero_rate: assert property (@(posedge clk) disable iff (!rst_n)
        (inc == '0) |=> !tick);

    // R9: slow rates never give back-to-back ticks
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && inc <= ACC_W'(1 << (ACC_W - 1))) |=> !tick);
endmodule

// File: rtl/baud_nco.sv
module baud_nco
    import baud_nco_pkg::*;
#(
    parameter int               ADDR_W  = 6,
    parameter int               DATA_W  = 32,
    parameter logic [ADDR_W-1:0] OFS_LO  = 6'h10,
    parameter logic [ADDR_W-1:0] OFS_CTL = 6'h14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              tx_busy,
    output logic              tick,
    output logic              enabled
);
    logic [ACC_W-1:0] inc;
    logic             en;

    baud_inc_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .OFS_LO (OFS_LO),
        .OFS_CTL(OFS_CTL)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .tx_busy(tx_busy),
        .inc    (inc),
        .en     (en)
    );

    baud_phase_acc u_acc (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (en),
        .inc  (inc),
        .tick (tick)
    );

    assign enabled = en;

    // R1: quiet after reset release
    a_r1_reset_quiet: assert property (@(posedge clk)
        $rose(rst_n) |-> (!tick && !enabled));
endmodule

// File: tb/sim_baud_nco.sv
module sim_baud_nco;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        tx_busy = 1'b0;
    logic        tick;
    logic        enabled;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    localparam logic [5:0] A_HI  = 6'h0C;
    localparam logic [5:0] A_LO  = 6'h10;
    localparam logic [5:0] A_CTL = 6'h14;

    always #2 clk = ~clk;

    baud_nco u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tx_busy(tx_busy), .tick(tick), .enabled(enabled)
    );

    function automatic longint exp_ticks(int inc, int n);
        return (longint'(n) * longint'(inc)) >> 16;
    endfunction

    task automatic check(string req, longint act, longint exp, int tol);
        total++;
        if (act > exp + tol || act < exp - tol) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic count(int n, output int ticks, output int pairs);
        logic prev = 1'b0;
        ticks = 0; pairs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (tick) ticks++;
            if (tick && prev) pairs++;
            prev = tick;
        end
    endtask

    // Program a rate with junk in the upper data bits (R2, R3), then enable.
    task automatic run_rate(string req, int inc, int n);
        int t, p;
        wr(A_CTL, 32'h0);
        wr(A_HI, {24'hA5C3_7E, 8'(inc >> 8)});
        wr(A_LO, {24'h5A3C_81, 8'(inc)});
        wr(A_CTL, 32'h1);
        count(n, t, p);
        check(req, t, exp_ticks(inc, n), 1);
        if (inc <= 32'h8000) check({req, " R9 pulse"}, p, 0, 0);
    endtask

    initial begin
        int t, p;
        int seed_v;
        seed_v = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        // R1
        check("R1 tick", tick, 0, 0);
        check("R1 enabled", enabled, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        wr(A_CTL, 32'h1);
        count(2000, t, p);
        check("R1 zero rate after reset", t, 0, 0);
        // R4
        check("R4 enabled high", enabled, 1, 0);
        wr(A_CTL, 32'hFFFF_FFFE);
        check("R4 enabled low", enabled, 0, 0);

        run_rate("R5 R2 R3 inc=0x8000", 32'h8000, 4096);
        run_rate("R5 R3 inc=0x0001", 32'h0001, 70000);
        run_rate("R5 inc=0x0100", 32'h0100, 8192);
        run_rate("R5 inc=0x4000", 32'h4000, 4096);
        run_rate("R5 inc=0xFFFF", 32'hFFFF, 4096);
        run_rate("R5 R2 inc=0x1200", 32'h1200, 4096);
        run_rate("R6 inc=0", 32'h0000, 4096);

        // R8: write while enabled has no effect
        run_rate("R5 inc=0x2000", 32'h2000, 2048);
        wr(A_HI, 32'h40); wr(A_LO, 32'h00);
        count(4096, t, p);
        check("R8 write while enabled", t, exp_ticks(32'h2000, 4096), 1);
        // R8: write while tx_busy has no effect
        wr(A_CTL, 32'h0);
        tx_busy = 1'b1;
        wr(A_HI, 32'h80); wr(A_LO, 32'h00);
        tx_busy = 1'b0;
        wr(A_CTL, 32'h1);
        count(4096, t, p);
        check("R8 write while busy", t, exp_ticks(32'h2000, 4096), 1);

        // R7: disabled means no ticks and restart from zero phase
        wr(A_CTL, 32'h0);
        count(1000, t, p);
        check("R7 disabled ticks", t, 0, 0);
        wr(A_CTL, 32'h1);
        count(3, t, p);
        check("R7 restart phase", t, exp_ticks(32'h2000, 3), 0);

        for (int i = 0; i < 6; i++) begin
            int r;
            r = int'($urandom() & 32'hFFFF);
            run_rate("R5 random", r, 6000);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule